// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protection Unit

This block keeps the status byte of a small serial EEPROM: the write enable latch, the busy flag and the two block-protect bits. The serial front end hands it the instruction byte once eight bits have been shifted in. At the end of a transfer it reports the chip-select rising edge together with the number of clock edges counted during that select period. For an array write it signals when the self-timed cycle starts and when it ends. The unit also samples the active-low write-protect pin and checks one array address against the protect map.

From these events the unit builds three things. The first is the status byte that the front end shifts out. The second is a write-permitted flag, which the front end tests before it starts an array write cycle. The third is a flag that marks the presented address as protected. The protect bits are modelled as a non-volatile register that a reset does not clear. A status write only takes effect after a timed programming cycle, and the busy flag is high for the whole of that cycle.

Top module: `eesr_status_unit`

## Requirements
- R1: `statusByte` reads 1111 in bits 7..4, the protect code in bits 3..2 (bit 3 is the upper bit), the enable latch in bit 1 and the busy flag in bit 0. After the first reset, with the factory protect code 00, it reads F0h.
- R2: An instruction byte takes effect only if bits 7..4 are zero. Bit 3 is ignored. Bits 2..0 select the command: 110 sets the latch, 100 clears it, 001 arms a status write, and 101 (status read) changes no state. Every other code has no effect.
- R3: The latch changes one cycle after the event that drives it. A set command sets it only while `wpN` is high and no cycle is busy. It is cleared by the clear command, by `wpN` low, by the end of a status programming cycle and by `arrayWrDone`. A clear wins over a set in the same cycle.
- R4: A status write starts a programming cycle only if all of these hold: an armed status-write command, `csRise` with `bitCount` exactly 16, the latch set, `wpN` high, and no cycle busy. In every other case nothing is written and busy stays low.
- R5: Busy goes high in the cycle after the commit and stays high for exactly `PROG_CYCLES` cycles. During that time the protect bits read their old value. In the cycle where busy falls, the new protect bits appear and the latch clears.
- R6: Only bits 3..2 of `wrsrByte` are stored. The data byte has no effect on bits 7..4 or on the latch, and the latch stays set, readable live, while the programming cycle runs.
- R7: `arrayWrStart` sets busy and `arrayWrDone` clears both busy and the latch. `wpN` going low during an array cycle clears the latch but leaves busy high. `writeAllowed` is high exactly when the latch is set, `wpN` is high and no cycle is busy.
- R8: For an `ADDR_W`-bit address, protect code 00 guards nothing, 01 guards the upper quarter, 10 guards the upper half and 11 guards the whole array. With 9 bits these ranges are 180h-1FFh, 100h-1FFh and 000h-1FFh.
- R9: `rstN` clears the latch and busy but keeps the protect bits.
- R10: While a cycle is busy, the set-latch and status-write commands are ignored. The clear-latch command still acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset of the volatile state |
| opValid | input | 1 | One-cycle strobe: an instruction byte has been received |
| opCode | input | 8 | The instruction byte |
| wrsrByte | input | 8 | Data byte of a status write, valid with `csRise` |
| csRise | input | 1 | One-cycle strobe: chip select has risen |
| bitCount | input | CNT_W | Clock edges counted in the select period that just ended |
| arrayWrStart | input | 1 | One-cycle strobe: an array write cycle starts |
| arrayWrDone | input | 1 | One-cycle strobe: the array write cycle has ended |
| wpN | input | 1 | Write-protect pin level, active low |
| addr | input | ADDR_W | Array address to check against the protect map |
| statusByte | output | 8 | Status byte for shifting out |
| writeAllowed | output | 1 | An array write may start now |
| addrProtected | output | 1 | `addr` lies in the protected region |

## Verification
Every strobe and pin input is registered once, so the latch, busy and protect results appear in the cycle after the input edge. The protect flag is combinational from `addr` and appears at once. The bench drives inputs on the falling edge and samples one rising edge later, on the next falling edge. For R5 the bench counts exactly `PROG_CYCLES` samples with busy high and then expects the new code on the following sample. Commands sent during a busy window are checked while the window is still open, and checked again after it closes.

// File: rtl/eesr_pkg.sv
package eesr_pkg;

  // low three opcode bits after masking bit 3; upper nibble must be zero
  localparam logic [7:0] OP_MASK  = 8'hF7;
  localparam logic [7:0] OP_SETWE = 8'h06;
  localparam logic [7:0] OP_CLRWE = 8'h04;
  localparam logic [7:0] OP_WRST  = 8'h01;

  localparam int STATUS_PROG_BITS = 16;

  typedef struct packed {
    logic setWel;     // set the enable latch
    logic clrWel;     // clear the enable latch (dominates)
    logic startProg;  // capture new protect code, begin programming
    logic loadBp;     // programming cycle ends, commit protect code
  } ctrlStrobe_t;

endpackage

// File: rtl/eesr_ctrl.sv
module eesr_ctrl
  import eesr_pkg::*;
#(
  parameter int PROG_CYCLES = 20,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [7:0]       opCode,
  input  logic             csRise,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             arrayWrStart,
  input  logic             arrayWrDone,
  input  logic             wpN,
  input  logic             welNow,
  output ctrlStrobe_t      strobe,
  output logic             wip
);

  localparam int PC_W = $clog2(PROG_CYCLES + 1);
  localparam logic [PC_W-1:0] PC_LOAD = PC_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] COMMIT_COUNT = CNT_W'(STATUS_PROG_BITS);

  logic [PC_W-1:0] progCnt;
  logic            arrBusy;
  logic            wrsrArmed;
  logic            progBusy;
  logic            isSetWe, isClrWe, isWrSt;
  logic            commitOk;

  assign progBusy = (progCnt != '0);
  assign wip      = progBusy | arrBusy;

  assign isSetWe = opValid && ((opCode & OP_MASK) == OP_SETWE);
  assign isClrWe = opValid && ((opCode & OP_MASK) == OP_CLRWE);
  assign isWrSt  = opValid && ((opCode & OP_MASK) == OP_WRST);

  assign commitOk = csRise && wrsrArmed && (bitCount == COMMIT_COUNT)
                    && welNow && wpN && !wip;

  always_comb begin
    strobe           = '0;
    strobe.setWel    = isSetWe && !wip;
    strobe.loadBp    = (progCnt == PC_W'(1));
    strobe.clrWel    = isClrWe || !wpN || strobe.loadBp || arrayWrDone;
    strobe.startProg = commitOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrsrArmed <= 1'b0;
    end else if (csRise) begin
      wrsrArmed <= 1'b0;
    end else if (isWrSt && !wip) begin
      wrsrArmed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progCnt <= '0;
    end else if (commitOk) begin
      progCnt <= PC_LOAD;
    end else if (progBusy) begin
      progCnt <= progCnt - PC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrBusy <= 1'b0;
    end else if (arrayWrDone) begin
      arrBusy <= 1'b0;
    end else if (arrayWrStart) begin
      arrBusy <= 1'b1;
    end
  end

endmodule

// File: rtl/eesr_dp.sv
module eesr_dp
  import eesr_pkg::*;
#(
  parameter int          ADDR_W     = 9,
  parameter logic [1:0]  FACTORY_BP = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        newBp,
  input  logic              wip,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] addr,
  output logic              welNow,
  output logic [7:0]        statusByte,
  output logic              writeAllowed,
  output logic              addrProtected
);

  localparam int TOP = ADDR_W - 1;

  logic [1:0] bpNv = FACTORY_BP;  // non-volatile model: untouched by rstN
  logic [1:0] bpPend;
  logic       wel;
  logic [1:0] topBits;
  logic [ADDR_W-3:0] unusedLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0;
    end else if (strobe.clrWel) begin
      wel <= 1'b0;
    end else if (strobe.setWel) begin
      wel <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.startProg) begin
      bpPend <= newBp;
    end
    if (strobe.loadBp) begin
      bpNv <= bpPend;
    end
  end

  assign welNow       = wel;
  assign statusByte   = {4'hF, bpNv, wel, wip};
  assign writeAllowed = wel && wpN && !wip;

  assign topBits   = addr[TOP -: 2];
  assign unusedLow = addr[ADDR_W-3:0];

  always_comb begin
    unique case (bpNv)
      2'b00:   addrProtected = 1'b0;
      2'b01:   addrProtected = (topBits == 2'b11);
      2'b10:   addrProtected = topBits[1];
      default: addrProtected = 1'b1;
    endcase
  end

endmodule

// File: rtl/eesr_status_unit.sv
module eesr_status_unit
  import eesr_pkg::*;
#(
  parameter int         ADDR_W      = 9,
  parameter int         PROG_CYCLES = 20,
  parameter int         CNT_W       = 8,
  parameter logic [1:0] FACTORY_BP  = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opCode,
  input  logic [7:0]        wrsrByte,
  input  logic              csRise,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic              arrayWrStart,
  input  logic              arrayWrDone,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        statusByte,
  output logic              writeAllowed,
  output logic              addrProtected
);

  ctrlStrobe_t strobe;
  logic        wip;
  logic        welNow;
  logic [5:0]  unusedData;

  assign unusedData = {wrsrByte[7:4], wrsrByte[1:0]};

  eesr_ctrl #(
    .PROG_CYCLES(PROG_CYCLES),
    .CNT_W      (CNT_W)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .opCode      (opCode),
    .csRise      (csRise),
    .bitCount    (bitCount),
    .arrayWrStart(arrayWrStart),
    .arrayWrDone (arrayWrDone),
    .wpN         (wpN),
    .welNow      (welNow),
    .strobe      (strobe),
    .wip         (wip)
  );

  eesr_dp #(
    .ADDR_W    (ADDR_W),
    .FACTORY_BP(FACTORY_BP)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .newBp        (wrsrByte[3:2]),
    .wip          (wip),
    .wpN          (wpN),
    .addr         (addr),
    .welNow       (welNow),
    .statusByte   (statusByte),
    .writeAllowed (writeAllowed),
    .addrProtected(addrProtected)
  );

endmodule

// File: rtl/eesr_status_chk.sv
module eesr_status_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wpN,
  input logic             csRise,
  input logic [CNT_W-1:0] bitCount,
  input logic             arrayWrStart,
  input logic [7:0]       statusByte,
  input logic             addrProtected
);

  // R3: a low protect pin leaves the latch clear on the next cycle
  a_r3_pin_clears_latch: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |=> !statusByte[1]);

  // R5: protect bits hold still across consecutive busy cycles
  a_r5_bp_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && $past(statusByte[0])) |-> $stable(statusByte[3:2]));

  // R10: no latch set while a cycle stays busy
  a_r10_no_set_busy: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && $past(statusByte[0])) |-> !$rose(statusByte[1]));

  // R4: a wrong edge count never starts programming
  a_r4_bad_count_idle: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && bitCount != CNT_W'(16) && !statusByte[0] && !arrayWrStart)
      |=> !statusByte[0]);

  // R8: code 11 guards everything, code 00 guards nothing
  a_r8_all_guarded: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[3:2] == 2'b11) |-> addrProtected);
  a_r8_none_guarded: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[3:2] == 2'b00) |-> !addrProtected);

endmodule

bind eesr_status_unit eesr_status_chk #(.CNT_W(CNT_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .wpN          (wpN),
  .csRise       (csRise),
  .bitCount     (bitCount),
  .arrayWrStart (arrayWrStart),
  .statusByte   (statusByte),
  .addrProtected(addrProtected)
);

// File: tb/tb_eesr_status_unit.sv
module tb_eesr_status_unit;

  localparam int ADDR_W = 9;
  localparam int PROG   = 20;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              opValid = 1'b0;
  logic [7:0]        opCode = '0;
  logic [7:0]        wrsrByte = '0;
  logic              csRise = 1'b0;
  logic [CNT_W-1:0]  bitCount = '0;
  logic              arrayWrStart = 1'b0;
  logic              arrayWrDone = 1'b0;
  logic              wpN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        statusByte;
  logic              writeAllowed;
  logic              addrProtected;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eesr_status_unit #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .wrsrByte(wrsrByte), .csRise(csRise), .bitCount(bitCount),
    .arrayWrStart(arrayWrStart), .arrayWrDone(arrayWrDone), .wpN(wpN),
    .addr(addr), .statusByte(statusByte), .writeAllowed(writeAllowed),
    .addrProtected(addrProtected)
  );

  // {protect code, address, expected flag}, for R8
  localparam int NMAP = 9;
  localparam logic [11:0] PMAP [NMAP] = '{
    {2'b00, 9'h1FF, 1'b0}, {2'b00, 9'h000, 1'b0},
    {2'b01, 9'h17F, 1'b0}, {2'b01, 9'h180, 1'b1}, {2'b01, 9'h1FF, 1'b1},
    {2'b10, 9'h0FF, 1'b0}, {2'b10, 9'h100, 1'b1},
    {2'b11, 9'h000, 1'b1}, {2'b11, 9'h0AB, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendOp(logic [7:0] op);
    opValid = 1'b1; opCode = op;
    tick();
    opValid = 1'b0;
  endtask

  task automatic csEnd(int n, logic [7:0] data);
    csRise = 1'b1; bitCount = CNT_W'(n); wrsrByte = data;
    tick();
    csRise = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4 * PROG && statusByte[0]; i++) tick();
  endtask

  task automatic programBp(logic [1:0] code);
    sendOp(8'h06); csEnd(8, 8'h00);
    sendOp(8'h01); csEnd(16, {4'h0, code, 2'b00});
    waitIdle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1 reset status", statusByte, 8'hF0);
    chk("R7 reset writeAllowed", writeAllowed, 0);

    // R2/R3 set with bit 3 high, clear with bit 3 high
    sendOp(8'h0E);
    chk("R2 R3 set latch", statusByte, 8'hF2);
    chk("R7 writeAllowed", writeAllowed, 1);
    sendOp(8'h0C);
    chk("R2 R3 clear latch", statusByte, 8'hF0);

    // R2 nonzero upper nibble and unused codes ignored
    sendOp(8'h16);
    chk("R2 upper nibble", statusByte, 8'hF0);
    sendOp(8'h06);
    sendOp(8'h02);
    sendOp(8'h05);
    chk("R2 unused and status-read codes", statusByte, 8'hF2);

    // R3 pin clears latch, set refused while pin low
    wpN = 1'b0; tick();
    chk("R3 pin low clears", statusByte, 8'hF0);
    sendOp(8'h06);
    chk("R3 set refused pin low", statusByte, 8'hF0);
    wpN = 1'b1; tick();

    // R4 wrong counts and missing latch
    sendOp(8'h06); csEnd(8, 8'h00);
    sendOp(8'h01); csEnd(15, 8'h0C); tick();
    chk("R4 count 15", statusByte, 8'hF2);
    sendOp(8'h01); csEnd(17, 8'h0C); tick();
    chk("R4 count 17", statusByte, 8'hF2);
    sendOp(8'h04); sendOp(8'h01); csEnd(16, 8'h0C); tick();
    chk("R4 latch clear", statusByte, 8'hF0);
    sendOp(8'h06); csEnd(8, 8'h00); csEnd(16, 8'h0C); tick();
    chk("R4 not armed", statusByte, 8'hF2);

    // R5/R6 programming window, data F4 stores code 01 only
    sendOp(8'h01); csEnd(16, 8'hF4);
    for (int k = 0; k < PROG; k++) begin
      chk("R5 R6 busy old code live latch", statusByte, 8'hF3);
      tick();
    end
    chk("R5 new code after window", statusByte, 8'hF4);

    // R10 during busy: clear acts, set and status write ignored
    sendOp(8'h06); csEnd(8, 8'h00);
    sendOp(8'h01); csEnd(16, 8'h08);
    chk("R10 busy start", statusByte, 8'hF7);
    sendOp(8'h04);
    chk("R10 clear acts while busy", statusByte, 8'hF5);
    sendOp(8'h06);
    chk("R10 set ignored while busy", statusByte, 8'hF5);
    sendOp(8'h01); csEnd(16, 8'h0C);
    waitIdle();
    chk("R10 second write dropped", statusByte, 8'hF8);
    tick(); tick();
    chk("R10 no second window", statusByte, 8'hF8);

    // R7 array cycle
    sendOp(8'h06);
    arrayWrStart = 1'b1; tick(); arrayWrStart = 1'b0;
    chk("R7 array busy", statusByte, 8'hFB);
    chk("R7 no write while busy", writeAllowed, 0);
    wpN = 1'b0; tick(); wpN = 1'b1;
    chk("R7 pin keeps busy", statusByte, 8'hF9);
    sendOp(8'h06); csEnd(8, 8'h00);
    arrayWrDone = 1'b1; tick(); arrayWrDone = 1'b0;
    chk("R7 done clears", statusByte, 8'hF8);

    // R9 reset keeps protect bits
    programBp(2'b11);
    sendOp(8'h06);
    rstN = 1'b0; tick(); rstN = 1'b1; tick();
    chk("R9 reset keeps code", statusByte, 8'hFC);

    // R8 protect map table
    for (int i = 0; i < NMAP; i++) begin
      if (statusByte[3:2] != PMAP[i][11:10]) programBp(PMAP[i][11:10]);
      addr = PMAP[i][9:1];
      #1;
      chk("R8 protect map", addrProtected, PMAP[i][0]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule